// File: doc/BRIEF.md
# Timestamped Input Event Capture

The block watches eight digital input lines. Every line first passes through a two-flop synchronizer. A change is detected by comparing the synchronized value with the value one clock earlier. When at least one line whose enable bit is set changes level, rising or falling, the block writes one 24-bit record into an eight-entry first-in, first-out buffer. The record holds the shared 16-bit free-running timer value and the new level of all eight lines.

Software, or a neighbouring block, reads records at the head of the buffer and pops them one at a time. The block reports empty and full status. It also provides an interrupt request that stays high while at least one record is waiting.

If a capture arrives while the buffer is full and no pop happens in the same cycle, the record is lost. A sticky overflow flag is set when that happens, and it is cleared by a status-read strobe.

Top module: `edge_stamp_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, overflow is 0 and irq is 0.
- R2: A level change on an enabled input that is held stable is written as a record at the third rising clock edge after it is presented. That is two synchronizer stages plus one edge-detect stage. The timer value stored is the one present on `timer` at that third edge.
- R3: Each record places the timer in bits 23:8 and the synchronized level of all eight inputs, after the change, in bits 7:0. Bit i is input i. Rising and falling changes both capture.
- R4: A change on an input whose bit in `chan_en` is 0 writes no record.
- R5: When several enabled inputs change in the same cycle, exactly one record is written, holding their combined new levels.
- R6: Records leave in the order they were written. `rd_data` shows the oldest record whenever empty is 0. A cycle with `rd_en` high and the buffer not empty pops it. `rd_en` while empty has no effect.
- R7: full is 1 when eight records are held. A capture while full, with no pop in the same cycle, is dropped, and the stored records stay unchanged.
- R8: A dropped capture sets overflow, which stays 1 until a cycle with `stat_rd` high. If a drop and `stat_rd` occur in the same cycle, overflow ends up set.
- R9: irq equals the inverse of empty at all times.
- R10: A capture and a pop in the same cycle while full both take effect: the oldest record leaves, the new one is appended, and full stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw input lines |
| chan_en | input | 8 | Per-line capture enable |
| timer | input | 16 | Shared free-running timer value |
| rd_en | input | 1 | Pop the head record |
| stat_rd | input | 1 | Status read strobe; clears overflow |
| rd_data | output | 24 | Head record {timer, levels} |
| empty | output | 1 | No record held |
| full | output | 1 | Eight records held |
| overflow | output | 1 | Sticky lost-capture flag |
| irq | output | 1 | Interrupt request, record waiting |

## Verification
The assertions assume that reset is applied with all inputs low, so the synchronizer starts equal to the lines. They also assume that `chan_en`, `rd_en` and `stat_rd` change only away from the rising clock edge. The bench drives every input on the falling edge and holds the lines at zero through reset. A behavioural queue model follows the same three-edge latency and is compared on every falling edge, through directed sequences and a long random phase that mixes enables, pops and status reads.

// File: rtl/edge_stamp_fifo.sv
module edge_stamp_fifo #(
  parameter int CH    = 8,
  parameter int TW    = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH-1:0]    pin_in,
  input  logic [CH-1:0]    chan_en,
  input  logic [TW-1:0]    timer,
  input  logic             rd_en,
  input  logic             stat_rd,
  output logic [TW+CH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int RW = TW + CH;

  logic [CH-1:0] sync1, sync2, last;
  logic [RW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp, count;
  logic          cap, pop, wr, drop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      last  <= sync2;
    end

  assign cap   = |((sync2 ^ last) & chan_en);
  assign count = wp - rp;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign pop   = rd_en && !empty;
  assign wr    = cap && (!full || pop);
  assign drop  = cap && full && !pop;
  assign irq   = !empty;
  assign rd_data = mem[rp[AW-1:0]];

  always_ff @(posedge clk)
    if (wr) mem[wp[AW-1:0]] <= {timer, sync2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr)  wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      if (drop)         overflow <= 1'b1;
      else if (stat_rd) overflow <= 1'b0;
    end
endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk #(
  parameter int CH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CH-1:0] chan_en,
  input logic          rd_en,
  input logic          stat_rd,
  input logic          empty,
  input logic          full,
  input logic          overflow,
  input logic          irq,
  input logic          wr,
  input logic          drop,
  input logic [CW-1:0] count
);
  a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r4_disabled_still: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en == '0 && !rd_en) |=> count == $past(count));

  a_r6_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !wr) |=> ($past(count) - count) == CW'(1));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !stat_rd) |=> overflow);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !drop) |=> !overflow);

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);

  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq != empty);
endmodule

bind edge_stamp_fifo edge_stamp_chk #(.CH(CH), .CW($clog2(DEPTH)+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rd_en(rd_en),
  .stat_rd(stat_rd), .empty(empty), .full(full), .overflow(overflow),
  .irq(irq), .wr(wr), .drop(drop), .count(count)
);

// File: tb/sim_edge_stamp_fifo.sv
module sim_edge_stamp_fifo;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0, chan_en = '0;
  logic [15:0] timer = '0;
  logic        rd_en = 1'b0, stat_rd = 1'b0;
  logic [23:0] rd_data;
  logic        empty, full, overflow, irq;

  int checks = 0, errors = 0, cycles = 0;

  logic [23:0] q[$];
  logic [7:0]  m1 = '0, m2 = '0, m3 = '0;
  bit          movf = 0;

  edge_stamp_fifo u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .chan_en(chan_en),
    .timer(timer), .rd_en(rd_en), .stat_rd(stat_rd), .rd_data(rd_data),
    .empty(empty), .full(full), .overflow(overflow), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m1 = '0; m2 = '0; m3 = '0; movf = 0;
    end else begin
      logic [7:0] ch;
      bit was_full, p, c;
      ch = (m2 ^ m3) & chan_en;
      c = (ch != 0);
      was_full = (q.size() == 8);
      p = rd_en && q.size() > 0;
      if (p) void'(q.pop_front());
      if (c && (!was_full || p)) q.push_back({timer, m2});
      if (stat_rd) movf = 0;
      if (c && was_full && !p) movf = 1;
      m3 = m2; m2 = m1; m1 = pin_in;
    end
  end

  task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (rst_n) begin
      chk("R6 empty", empty == (q.size() == 0), 32'(empty), 32'(q.size() == 0));
      chk("R7 full", full == (q.size() == 8), 32'(full), 32'(q.size() == 8));
      chk("R8 overflow", overflow == movf, 32'(overflow), 32'(movf));
      chk("R9 irq", irq == (q.size() != 0), 32'(irq), 32'(q.size() != 0));
      if (q.size() != 0) chk("R6 head", rd_data == q[0], 32'(rd_data), 32'(q[0]));
    end
    timer = timer + 16'd1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(negedge clk) begin
    if (cycles > LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] t0;
    logic [15:0] prev;
    ticks(3);
    rst_n = 1'b1;
    tick();
    chk("R1 empty", empty == 1'b1, 32'(empty), 1);
    chk("R1 full", full == 1'b0, 32'(full), 0);
    chk("R1 overflow", overflow == 1'b0, 32'(overflow), 0);
    chk("R1 irq", irq == 1'b0, 32'(irq), 0);

    chan_en = 8'hFF;
    t0 = timer; pin_in = 8'h01;
    ticks(2);
    chk("R2 latency", empty == 1'b1, 32'(empty), 1);
    tick();
    chk("R2 R3 record", rd_data == {t0 + 16'd2, 8'h01}, 32'(rd_data), 32'({t0 + 16'd2, 8'h01}));
    t0 = timer; pin_in = 8'h00;
    ticks(3);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R3 falling", rd_data == {t0 + 16'd2, 8'h00}, 32'(rd_data), 32'({t0 + 16'd2, 8'h00}));
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R6 drained", empty == 1'b1, 32'(empty), 1);

    chan_en = 8'h0F;
    pin_in = 8'h80; ticks(2); pin_in = 8'h00; ticks(2); pin_in = 8'hC0; ticks(4);
    chk("R4 disabled", empty == 1'b1, 32'(empty), 1);
    t0 = timer; pin_in = 8'hC2; ticks(3);
    chk("R3 snapshot", rd_data == {t0 + 16'd2, 8'hC2}, 32'(rd_data), 32'({t0 + 16'd2, 8'hC2}));
    rd_en = 1'b1; tick(); rd_en = 1'b0;

    pin_in = 8'hCD; ticks(4);
    chk("R5 one record", empty == 1'b0 && q.size() == 1, 32'(q.size()), 1);
    chk("R5 combined", rd_data[7:0] == 8'hCD, 32'(rd_data[7:0]), 32'h CD);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R5 single pop", empty == 1'b1, 32'(empty), 1);

    rd_en = 1'b1; ticks(2); rd_en = 1'b0;
    chk("R6 empty read", empty == 1'b1, 32'(empty), 1);

    chan_en = 8'h01;
    for (int i = 0; i < 10; i++) begin pin_in[0] = ~pin_in[0]; tick(); end
    ticks(3);
    chk("R7 full", full == 1'b1, 32'(full), 1);
    chk("R8 set", overflow == 1'b1, 32'(overflow), 1);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    chk("R8 cleared", overflow == 1'b0, 32'(overflow), 0);

    prev = rd_data[23:8];
    pin_in[0] = ~pin_in[0]; ticks(2);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R10 still full", full == 1'b1, 32'(full), 1);
    chk("R10 no overflow", overflow == 1'b0, 32'(overflow), 0);
    chk("R10 head moved", rd_data[23:8] == prev + 16'd1, 32'(rd_data[23:8]), 32'(prev + 16'd1));

    pin_in[0] = ~pin_in[0]; ticks(2);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    chk("R8 set wins", overflow == 1'b1, 32'(overflow), 1);

    prev = rd_data[23:8];
    for (int i = 0; i < 7; i++) begin
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      chk("R6 order", rd_data[23:8] > prev, 32'(rd_data[23:8]), 32'(prev));
      prev = rd_data[23:8];
    end
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R6 empty end", empty == 1'b1, 32'(empty), 1);

    for (int i = 0; i < 3000; i++) begin
      pin_in  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pin_in;
      chan_en = ($urandom_range(0, 50) == 0) ? 8'($urandom) : chan_en;
      rd_en   = ($urandom_range(0, 2) == 0);
      stat_rd = ($urandom_range(0, 20) == 0);
      tick();
    end
    rd_en = 1'b0; stat_rd = 1'b0;
    ticks(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule